// File: doc/BRIEF.md
# Crossbar Multiplier Mesh

This block is a rectangular mesh of identical arithmetic cells that share one clock. Each cell has four directional data ports: left, up, right and down. On every clock edge the cell latches the four values it receives from its neighbours, or from the mesh boundary. On the next edge it latches four truncated products formed from fixed pairs of those latched values. Each product goes out on one side of the cell, so data moves one cell per two clock cycles in each of the four directions. Every product is the product of the operands that arrive from two adjacent sides.

Each row also carries a one-bit chain from left to right, alongside the data mesh. The bit passes straight through most columns without a register. A pipeline flop sits after every half-row of columns. This gives a fixed latency of a few cycles from the row's chain input to its chain output.

The boundary is flat buses with one lane per edge cell. Lane k of a bus occupies bits [k*DW +: DW]. The mesh size and the lane width are parameters.

Top module: `mesh_mul_grid`

## Requirements
- R1: The mesh holds ROWS x COLS identical cells, with defaults 4x4 and DW=8 (an 8x8 mesh is a parameter change). West and east buses carry lane r for row r. North and south buses carry lane c for column c. Each lane sits at bits [lane*DW +: DW].
- R2: Each cell captures its four inputs in registers on the clock edge before any product is formed, so an input change cannot reach any output within one cycle.
- R3: In each cell, the left operand times the up operand drives the right output. Up times right drives the down output. Right times down drives the left output. Down times left drives the up output. Each product keeps only its low DW bits.
- R4: The products are registered before leaving the cell, so a value presented to a cell appears in that cell's outputs exactly two edges later.
- R5: A cell's right output feeds the left input of the cell to its right, and its left output feeds the right input of the cell to its left. A cell's down output feeds the up input of the cell below, and its up output feeds the down input of the cell above. Boundary sides connect to the lanes of the west, east, north and south buses.
- R6: The chain bit for row r enters at column 0 and leaves on chain_out[r]. The chain is registered after every column c where (c+1) is a multiple of COLS/2, and passes combinationally everywhere else. With the default sizes the latency is two edges.
- R7: A synchronous active-high reset clears every operand register, product register and chain register to zero. All outputs therefore read zero after a reset edge.
- R8: The chain bits of the rows are independent: each chain_out bit depends only on the chain_in bit of the same row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock |
| rst | input | 1 | Synchronous active-high reset |
| west_in | input | ROWS*DW | Left operands of column 0, one lane per row |
| west_out | output | ROWS*DW | Left outputs of column 0 |
| east_in | input | ROWS*DW | Right operands of the last column |
| east_out | output | ROWS*DW | Right outputs of the last column |
| north_in | input | COLS*DW | Up operands of row 0, one lane per column |
| north_out | output | COLS*DW | Up outputs of row 0 |
| south_in | input | COLS*DW | Down operands of the last row |
| south_out | output | COLS*DW | Down outputs of the last row |
| chain_in | input | ROWS | Chain bit entering each row |
| chain_out | output | ROWS | Chain bit leaving each row |

## Verification
The assertions check four behaviours on every cycle in every cell: the operand latching, the four crossbar products, the clearing on reset and the two-edge chain delay. One corner cell is also checked from its operands to the east port. Only the bench scenarios can show that values cross the mesh from cell to cell and reach the correct boundary lane in the expected cycle. The bench sends products through a whole row or column in each of the four directions and checks truncation on a wrapped product. It also runs long pseudo-random traffic against a cycle model of the mesh.

// File: rtl/mesh_mul_grid.sv
module mesh_mul_grid #(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int DW   = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ROWS*DW-1:0]   west_in,
  output logic [ROWS*DW-1:0]   west_out,
  input  logic [ROWS*DW-1:0]   east_in,
  output logic [ROWS*DW-1:0]   east_out,
  input  logic [COLS*DW-1:0]   north_in,
  output logic [COLS*DW-1:0]   north_out,
  input  logic [COLS*DW-1:0]   south_in,
  output logic [COLS*DW-1:0]   south_out,
  input  logic [ROWS-1:0]      chain_in,
  output logic [ROWS-1:0]      chain_out
);
  localparam int N   = ROWS * COLS;
  localparam int SEG = (COLS / 2 > 0) ? COLS / 2 : 1;

  logic [DW-1:0] src_l [N];
  logic [DW-1:0] src_u [N];
  logic [DW-1:0] src_r [N];
  logic [DW-1:0] src_d [N];
  logic [DW-1:0] lq [N];
  logic [DW-1:0] uq [N];
  logic [DW-1:0] rq [N];
  logic [DW-1:0] dq [N];
  logic [DW-1:0] yr [N];
  logic [DW-1:0] yd [N];
  logic [DW-1:0] yl [N];
  logic [DW-1:0] yu [N];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int K = r * COLS + c;

      if (c == 0) begin : g_lw
        assign src_l[K] = west_in[r*DW +: DW];
      end else begin : g_ln
        assign src_l[K] = yr[K-1];
      end
      if (c == COLS - 1) begin : g_re
        assign src_r[K] = east_in[r*DW +: DW];
      end else begin : g_rn
        assign src_r[K] = yl[K+1];
      end
      if (r == 0) begin : g_un
        assign src_u[K] = north_in[c*DW +: DW];
      end else begin : g_uc
        assign src_u[K] = yd[K-COLS];
      end
      if (r == ROWS - 1) begin : g_ds
        assign src_d[K] = south_in[c*DW +: DW];
      end else begin : g_dc
        assign src_d[K] = yu[K+COLS];
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          lq[K] <= '0; uq[K] <= '0; rq[K] <= '0; dq[K] <= '0;
          yr[K] <= '0; yd[K] <= '0; yl[K] <= '0; yu[K] <= '0;
        end else begin
          lq[K] <= src_l[K];
          uq[K] <= src_u[K];
          rq[K] <= src_r[K];
          dq[K] <= src_d[K];
          yr[K] <= lq[K] * uq[K];
          yd[K] <= uq[K] * rq[K];
          yl[K] <= rq[K] * dq[K];
          yu[K] <= dq[K] * lq[K];
        end
      end
    end

    assign west_out[r*DW +: DW] = yl[r*COLS];
    assign east_out[r*DW +: DW] = yr[r*COLS + COLS - 1];

    logic [COLS:0] lnk;
    assign lnk[0] = chain_in[r];
    for (genvar c = 0; c < COLS; c++) begin : g_chn
      if (((c + 1) % SEG) == 0) begin : g_brk
        logic q;
        always_ff @(posedge clk) begin
          if (rst) q <= 1'b0;
          else     q <= lnk[c];
        end
        assign lnk[c+1] = q;
      end else begin : g_thru
        assign lnk[c+1] = lnk[c];
      end
    end
    assign chain_out[r] = lnk[COLS];
  end

  for (genvar c = 0; c < COLS; c++) begin : g_edge
    assign north_out[c*DW +: DW] = yu[c];
    assign south_out[c*DW +: DW] = yd[(ROWS-1)*COLS + c];
  end
endmodule

// File: rtl/mesh_mul_grid_chk.sv
module mesh_mul_grid_chk #(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int DW   = 8
) (
  input logic               clk,
  input logic               rst,
  input logic [DW-1:0]      src_l [ROWS*COLS],
  input logic [DW-1:0]      src_u [ROWS*COLS],
  input logic [DW-1:0]      src_r [ROWS*COLS],
  input logic [DW-1:0]      src_d [ROWS*COLS],
  input logic [DW-1:0]      lq [ROWS*COLS],
  input logic [DW-1:0]      uq [ROWS*COLS],
  input logic [DW-1:0]      rq [ROWS*COLS],
  input logic [DW-1:0]      dq [ROWS*COLS],
  input logic [DW-1:0]      yr [ROWS*COLS],
  input logic [DW-1:0]      yd [ROWS*COLS],
  input logic [DW-1:0]      yl [ROWS*COLS],
  input logic [DW-1:0]      yu [ROWS*COLS],
  input logic [ROWS*DW-1:0] east_out,
  input logic [ROWS-1:0]    chain_in,
  input logic [ROWS-1:0]    chain_out
);
  localparam int N   = ROWS * COLS;
  localparam int SEG = (COLS / 2 > 0) ? COLS / 2 : 1;
  localparam int K0  = COLS - 1;

  logic [1:0] age;
  logic       seen;
  always_ff @(posedge clk) begin
    seen <= 1'b1;
    if (rst)            age <= 2'd0;
    else if (age != 3)  age <= age + 2'd1;
  end

  for (genvar k = 0; k < N; k++) begin : g_cell
    assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
      (age >= 1) |-> (lq[k] == $past(src_l[k]) && uq[k] == $past(src_u[k]) &&
                      rq[k] == $past(src_r[k]) && dq[k] == $past(src_d[k])));
    assert_crossbar_R3: assert property (@(posedge clk) disable iff (rst)
      (age >= 1) |-> (yr[k] == $past(lq[k] * uq[k]) && yd[k] == $past(uq[k] * rq[k]) &&
                      yl[k] == $past(rq[k] * dq[k]) && yu[k] == $past(dq[k] * lq[k])));
    assert_clear_R7: assert property (@(posedge clk)
      (seen && $past(rst)) |-> (lq[k] == '0 && uq[k] == '0 && rq[k] == '0 && dq[k] == '0 &&
                                yr[k] == '0 && yd[k] == '0 && yl[k] == '0 && yu[k] == '0));
  end

  assert_latency_R4: assert property (@(posedge clk) disable iff (rst)
    (age >= 2) |-> (east_out[0 +: DW] == $past(src_l[K0] * src_u[K0], 2)));

  if ((COLS % SEG) == 0 && (COLS / SEG) == 2) begin : g_chain2
    assert_chain_delay_R6: assert property (@(posedge clk) disable iff (rst)
      (age >= 2) |-> (chain_out == $past(chain_in, 2)));
  end
endmodule

bind mesh_mul_grid mesh_mul_grid_chk #(.ROWS(ROWS), .COLS(COLS), .DW(DW)) u_chk (.*);

// File: tb/mesh_mul_grid_test.sv
module mesh_mul_grid_test;
  localparam int R = 4;
  localparam int C = 4;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [R*W-1:0] west_in = '0, east_in = '0;
  logic [C*W-1:0] north_in = '0, south_in = '0;
  logic [R-1:0]   chain_in = '0;
  logic [R*W-1:0] west_out, east_out;
  logic [C*W-1:0] north_out, south_out;
  logic [R-1:0]   chain_out;

  int checks = 0;
  int failures = 0;
  logic [31:0] seed = 32'h1234_5678;

  logic [W-1:0] ml [R][C], mu [R][C], mr [R][C], md [R][C];
  logic [W-1:0] mor [R][C], mod [R][C], mol [R][C], mou [R][C];
  logic [R-1:0] ch1 = '0, ch2 = '0;

  mesh_mul_grid #(.ROWS(R), .COLS(C), .DW(W)) uut (.*);

  always #10 clk = ~clk;

  initial begin
    #4_000_000;
    checks++;
    failures++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // cycle model built from R3, R5, R6, R7
  task automatic tick();
    logic [W-1:0] nl [R][C], nu [R][C], nr [R][C], nd [R][C];
    logic [W-1:0] a [R][C], b [R][C], e [R][C], f [R][C];
    for (int r = 0; r < R; r++)
      for (int c = 0; c < C; c++) begin
        if (c == 0) nl[r][c] = west_in[r*W +: W]; else nl[r][c] = mor[r][c-1];
        if (c == C-1) nr[r][c] = east_in[r*W +: W]; else nr[r][c] = mol[r][c+1];
        if (r == 0) nu[r][c] = north_in[c*W +: W]; else nu[r][c] = mod[r-1][c];
        if (r == R-1) nd[r][c] = south_in[c*W +: W]; else nd[r][c] = mou[r+1][c];
        a[r][c] = W'(ml[r][c] * mu[r][c]);
        b[r][c] = W'(mu[r][c] * mr[r][c]);
        e[r][c] = W'(mr[r][c] * md[r][c]);
        f[r][c] = W'(md[r][c] * ml[r][c]);
      end
    @(posedge clk);
    for (int r = 0; r < R; r++)
      for (int c = 0; c < C; c++) begin
        ml[r][c]  = rst ? '0 : nl[r][c];
        mu[r][c]  = rst ? '0 : nu[r][c];
        mr[r][c]  = rst ? '0 : nr[r][c];
        md[r][c]  = rst ? '0 : nd[r][c];
        mor[r][c] = rst ? '0 : a[r][c];
        mod[r][c] = rst ? '0 : b[r][c];
        mol[r][c] = rst ? '0 : e[r][c];
        mou[r][c] = rst ? '0 : f[r][c];
      end
    ch2 = rst ? '0 : ch1;
    ch1 = rst ? '0 : chain_in;
    @(negedge clk);
    for (int r = 0; r < R; r++) begin
      check("R5", "west_out lane", 32'(west_out[r*W +: W]), 32'(mol[r][0]));
      check("R5", "east_out lane", 32'(east_out[r*W +: W]), 32'(mor[r][C-1]));
    end
    for (int c = 0; c < C; c++) begin
      check("R5", "north_out lane", 32'(north_out[c*W +: W]), 32'(mou[0][c]));
      check("R5", "south_out lane", 32'(south_out[c*W +: W]), 32'(mod[R-1][c]));
    end
    check("R6", "chain_out model", 32'(chain_out), 32'(ch2));
  endtask

  task automatic do_reset();
    west_in = '0; east_in = '0; north_in = '0; south_in = '0; chain_in = '0;
    rst = 1'b1;
    tick();
    tick();
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R7", "west_out after reset", 32'(west_out), 0);
    check("R7", "east_out after reset", 32'(east_out), 0);
    check("R7", "north_out after reset", 32'(north_out), 0);
    check("R7", "south_out after reset", 32'(south_out), 0);
    check("R7", "chain_out after reset", 32'(chain_out), 0);
  endtask

  task automatic t_east(input logic [W-1:0] w0, input logic [W-1:0] n0,
                        input logic [W-1:0] n1, input logic [31:0] exp);
    do_reset();
    west_in[0 +: W] = w0;
    north_in = {8'd1, 8'd1, n1, n0};
    tick();
    check("R2", "east_out one edge after input", 32'(east_out[0 +: W]), 0);
    for (int i = 0; i < 6; i++) tick();
    check("R4", "east_out before 8th edge", 32'(east_out[0 +: W]), 0);
    tick();
    check("R3", "east_out row0 product", 32'(east_out[0 +: W]), exp);
  endtask

  task automatic t_west();
    do_reset();
    east_in[3*W +: W] = 8'd2;
    south_in = {8'd2, 8'd3, 8'd1, 8'd1};
    for (int i = 0; i < 7; i++) tick();
    check("R4", "west_out row3 before 8th edge", 32'(west_out[3*W +: W]), 0);
    tick();
    check("R5", "west_out row3 product", 32'(west_out[3*W +: W]), 12);
  endtask

  task automatic t_down();
    do_reset();
    north_in[3*W +: W] = 8'd4;
    east_in = {8'd1, 8'd1, 8'd1, 8'd3};
    for (int i = 0; i < 8; i++) tick();
    check("R5", "south_out col3 product", 32'(south_out[3*W +: W]), 12);
  endtask

  task automatic t_up();
    do_reset();
    south_in[0 +: W] = 8'd5;
    west_in = {8'd2, 8'd1, 8'd1, 8'd1};
    for (int i = 0; i < 8; i++) tick();
    check("R5", "north_out col0 product", 32'(north_out[0 +: W]), 10);
  endtask

  task automatic t_chain();
    do_reset();
    chain_in = 4'b1010;
    tick();
    chain_in = 4'b0000;
    check("R6", "chain_out after one edge", 32'(chain_out), 0);
    tick();
    check("R6", "chain_out after two edges", 32'(chain_out), 32'b1010);
    chain_in = 4'b0101;
    tick();
    chain_in = 4'b0000;
    tick();
    check("R8", "chain rows independent", 32'(chain_out), 32'b0101);
  endtask

  task automatic t_random();
    do_reset();
    for (int i = 0; i < 300; i++) begin
      seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
      west_in = seed;
      north_in = {seed[15:0], seed[31:16]};
      east_in = ~seed;
      south_in = seed ^ 32'h5a5a_a5a5;
      chain_in = seed[7:4];
      tick();
    end
    check("R1", "mesh active after traffic", 32'(|{west_out, east_out, north_out, south_out}), 1);
    rst = 1'b1;
    tick();
    rst = 1'b0;
    check("R7", "outputs cleared by mid-run reset",
          32'(|{west_out, east_out, north_out, south_out, chain_out}), 0);
  endtask

  initial begin
    for (int r = 0; r < R; r++)
      for (int c = 0; c < C; c++) begin
        ml[r][c] = '0; mu[r][c] = '0; mr[r][c] = '0; md[r][c] = '0;
        mor[r][c] = '0; mod[r][c] = '0; mol[r][c] = '0; mou[r][c] = '0;
      end
    t_reset();
    t_east(8'd3, 8'd5, 8'd2, 30);
    t_east(8'd17, 8'd17, 8'd1, 33);
    t_west();
    t_down();
    t_up();
    t_chain();
    t_random();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule